// File: doc/BRIEF.md
# Dual-Clock Elastic Store with Frame-Aligned Justification

This block sits where a byte stream timed by a foreign line clock has to be handed to a local frame clock. Bytes arrive with a write strobe on the write clock. They leave on the read clock whenever the local framer offers a byte slot. The two clocks are never exactly equal, so the amount held in the store drifts. A slower writer drains the store toward empty, and a faster writer fills it.

Running dry or spilling over would corrupt data. Instead, the store watches its fill level in the read domain and raises a justification request when the level reaches a low or a high threshold. The local framer then moves the payload pointer by one byte at the next frame boundary. In a positive justification, the first normal byte slot of that frame is left unused. In a negative justification, the spare slot of that frame carries one extra payload byte.

Read and write positions cross between the clock domains as Gray-coded counters through two-flop synchronisers. Only the payload that comes from the foreign domain passes through this store. Locally timed payloads that share the outgoing frame need none of this.

Top module: `elastic_store`

## Requirements
- R1: After reset the store counts as holding half its depth (8 of 16 bytes), both justification requests are low and rdValid is low.
- R2: Bytes come out on rdData in the order they were accepted on the write side, with nothing lost or repeated, while the write and read clocks run at different rates.
- R3: A write strobe is ignored while the store holds 16 bytes, so only the first 16 of a longer burst into an empty store are later read out.
- R4: A byte request while the store is empty returns rdValid low and does not move the read position.
- R5: When the read-side fill is 4 or less, justInc is set and stays set until the next frameStart.
- R6: When the read-side fill is 12 or more and no request is held, justDec is set and stays set until the next frameStart.
- R7: At most one of justInc and justDec is held within a frame. A frameStart hands the held request to the new frame and re-evaluates the fill in that same cycle, so a level still past a threshold raises the request again at once.
- R8: A justInc held at a frameStart makes the first rdReq of the new frame return rdValid low without consuming a byte. Later slots of that frame read normally.
- R9: A justDec held at a frameStart makes the spare slot of the new frame (rdSpare high while rdReq is low) return a byte with rdValid high. In any other frame the spare slot returns rdValid low.
- R10: A byte granted to rdReq or rdSpare appears on rdData, with rdValid high, one rdClk cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Line (write) clock |
| wrRstN | input | 1 | Active-low asynchronous reset, write domain |
| wrStb | input | 1 | Write strobe: wrData is offered this cycle |
| wrData | input | 8 | Payload byte to store |
| rdClk | input | 1 | Local frame (read) clock |
| rdRstN | input | 1 | Active-low asynchronous reset, read domain |
| frameStart | input | 1 | One-cycle pulse before the first byte slot of a frame |
| rdReq | input | 1 | Normal payload byte slot |
| rdSpare | input | 1 | Spare (negative justification) slot, used only while rdReq is low |
| rdData | output | 8 | Byte read out |
| rdValid | output | 1 | rdData holds a payload byte this cycle |
| justInc | output | 1 | Positive justification requested for the next frame |
| justDec | output | 1 | Negative justification requested for the next frame |

## Verification
Two functions can fall in the same read cycle: handing the held request over to the new frame, and latching a fresh threshold request. The bench provokes this by pulsing frameStart while the fill sits exactly at 12, and later exactly at 4. It judges the result by the request staying raised after the pulse and by the frame that follows also skipping a slot or filling its spare slot. It also pulses frameStart after the level has moved just inside a threshold, and checks that the request then drops while the handed-over justification still takes effect.

// File: rtl/es_pkg.sv
package es_pkg;
  // read-side strobes from control to datapath
  typedef struct packed {
    logic pop;   // consume one byte and present it next cycle
  } rdStrobe_t;
endpackage

// File: rtl/es_gray_sync.sv
module es_gray_sync #(
  parameter int W = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/es_datapath.sv
module es_datapath
  import es_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  rdStrobe_t         strobe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [ADDR_W:0]   rdFill
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] HALF_BIN  = PTR_W'(DEPTH / 2);
  localparam logic [PTR_W-1:0] HALF_GRAY = HALF_BIN ^ (HALF_BIN >> 1);
  localparam logic [PTR_W-1:0] FULL_LVL  = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_ONE   = PTR_W'(1);

  function automatic logic [PTR_W-1:0] binToGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] grayToBin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];

  // ---------------- write domain ----------------
  logic [PTR_W-1:0] wrBin, wrGray, rdGrayW, wrFill;
  logic             wrFull, wrAccept;

  es_gray_sync #(.W(PTR_W), .RST_VAL('0)) rdToWr_i (
    .clk(wrClk), .rstN(wrRstN), .d(rdGray), .q(rdGrayW)
  );

  assign wrFill   = wrBin - grayToBin(rdGrayW);
  assign wrFull   = (wrFill == FULL_LVL);
  assign wrAccept = wrStb & ~wrFull;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin  <= HALF_BIN;
      wrGray <= HALF_GRAY;
    end else if (wrAccept) begin
      wrBin  <= wrBin + PTR_ONE;
      wrGray <= binToGray(wrBin + PTR_ONE);
    end
  end

  always_ff @(posedge wrClk) begin
    if (wrAccept) mem[wrBin[ADDR_W-1:0]] <= wrData;
  end

  AST_NO_OVERFLOW: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrStb && wrFull) |=> $stable(wrBin)); // R3

  // ---------------- read domain ----------------
  logic [PTR_W-1:0] rdBin, rdGray, wrGrayR;

  es_gray_sync #(.W(PTR_W), .RST_VAL(HALF_GRAY)) wrToRd_i (
    .clk(rdClk), .rstN(rdRstN), .d(wrGray), .q(wrGrayR)
  );

  assign rdFill = grayToBin(wrGrayR) - rdBin;

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin   <= '0;
      rdGray  <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.pop;
      if (strobe.pop) begin
        rdData <= mem[rdBin[ADDR_W-1:0]];
        rdBin  <= rdBin + PTR_ONE;
        rdGray <= binToGray(rdBin + PTR_ONE);
      end
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge rdClk) disable iff (!rdRstN)
    strobe.pop |-> (rdFill != '0)); // R4
endmodule

// File: rtl/es_ctrl.sv
module es_ctrl
  import es_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int LOW_TH  = 4,
  parameter int HIGH_TH = 12
) (
  input  logic            rdClk,
  input  logic            rdRstN,
  input  logic            frameStart,
  input  logic            rdReq,
  input  logic            rdSpare,
  input  logic [ADDR_W:0] rdFill,
  output rdStrobe_t       strobe,
  output logic            justInc,
  output logic            justDec
);
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] LOW_LVL  = PTR_W'(LOW_TH);
  localparam logic [PTR_W-1:0] HIGH_LVL = PTR_W'(HIGH_TH);

  logic reqInc, reqDec, actInc, actDec;
  logic lowHit, highHit, notEmpty, spareSlot;

  assign lowHit    = (rdFill <= LOW_LVL);
  assign highHit   = (rdFill >= HIGH_LVL) & ~lowHit;
  assign notEmpty  = (rdFill != '0);
  assign spareSlot = rdSpare & ~rdReq;

  assign strobe.pop = notEmpty & ((rdReq & ~actInc) | (spareSlot & actDec));
  assign justInc    = reqInc;
  assign justDec    = reqDec;

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      reqInc <= 1'b0;
      reqDec <= 1'b0;
      actInc <= 1'b0;
      actDec <= 1'b0;
    end else if (frameStart) begin
      actInc <= reqInc;
      actDec <= reqDec;
      reqInc <= lowHit;
      reqDec <= highHit;
    end else begin
      if (!reqInc && !reqDec) begin
        reqInc <= lowHit;
        reqDec <= highHit;
      end
      if (rdReq) actInc <= 1'b0;
      if (spareSlot) actDec <= 1'b0;
    end
  end

  AST_INC_HELD: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (reqInc && !frameStart) |=> reqInc); // R5
  AST_DEC_HELD: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (reqDec && !frameStart) |=> reqDec); // R6
  AST_SINGLE_REQ: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !(justInc && justDec)); // R7
  AST_FRAME_HANDOVER: assert property (@(posedge rdClk) disable iff (!rdRstN)
    frameStart |=> (actInc == $past(reqInc)) && (actDec == $past(reqDec))); // R8
endmodule

// File: rtl/elastic_store.sv
module elastic_store #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int LOW_TH  = 4,
  parameter int HIGH_TH = 12
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              frameStart,
  input  logic              rdReq,
  input  logic              rdSpare,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              justInc,
  output logic              justDec
);
  es_pkg::rdStrobe_t strobe;
  logic [ADDR_W:0]   rdFill;

  es_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp_i (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrStb(wrStb), .wrData(wrData),
    .rdClk(rdClk), .rdRstN(rdRstN), .strobe(strobe),
    .rdData(rdData), .rdValid(rdValid), .rdFill(rdFill)
  );

  es_ctrl #(.ADDR_W(ADDR_W), .LOW_TH(LOW_TH), .HIGH_TH(HIGH_TH)) ctl_i (
    .rdClk(rdClk), .rdRstN(rdRstN), .frameStart(frameStart),
    .rdReq(rdReq), .rdSpare(rdSpare), .rdFill(rdFill),
    .strobe(strobe), .justInc(justInc), .justDec(justDec)
  );

  AST_EMPTY_SILENT: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdReq && rdFill == '0) |=> !rdValid); // R4
endmodule

// File: tb/elastic_store_tb_top.sv
`timescale 1ns/1ps
module elastic_store_tb_top;
  logic       wrClk = 1'b0, rdClk = 1'b0;
  logic       wrRstN = 1'b0, rdRstN = 1'b0;
  logic       wrStb = 1'b0, frameStart = 1'b0, rdReq = 1'b0, rdSpare = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       rdValid, justInc, justDec;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4   rdClk = ~rdClk;   // 125 MHz local frame clock
  always #4.2 wrClk = ~wrClk;   // slightly slower line clock

  elastic_store dut_i (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrStb(wrStb), .wrData(wrData),
    .rdClk(rdClk), .rdRstN(rdRstN), .frameStart(frameStart),
    .rdReq(rdReq), .rdSpare(rdSpare), .rdData(rdData),
    .rdValid(rdValid), .justInc(justInc), .justDec(justDec)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wrByte(input logic [7:0] d);
    @(negedge wrClk); wrStb = 1'b1; wrData = d;
    @(negedge wrClk); wrStb = 1'b0;
  endtask

  task automatic rdIdle(input int n);
    repeat (n) @(negedge rdClk);
  endtask

  task automatic fsPulse();
    @(negedge rdClk); frameStart = 1'b1;
    @(negedge rdClk); frameStart = 1'b0;
  endtask

  // one slot: useSpare selects the spare slot instead of a normal slot
  task automatic rdSlot(input bit useSpare, output logic v, output logic [7:0] d);
    @(negedge rdClk); rdReq = !useSpare; rdSpare = useSpare;
    @(negedge rdClk); rdReq = 1'b0; rdSpare = 1'b0;
    v = rdValid; d = rdData;
  endtask

  initial begin
    repeat (100000) @(posedge rdClk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic       v;
    logic [7:0] d;
    int         modelFill;

    rdIdle(4);
    wrRstN = 1'b1; rdRstN = 1'b1;
    rdIdle(5);
    modelFill = 8;
    // R1 reset state
    chk(rdValid == 1'b0, "R1 rdValid", int'(rdValid), 0);
    chk(justInc == 1'b0, "R1 justInc", int'(justInc), 0);
    chk(justDec == 1'b0, "R1 justDec", int'(justDec), 0);

    // raise fill to 12
    for (int i = 0; i < 4; i++) wrByte(8'hA0 + 8'(i));
    modelFill += 4;
    rdIdle(8);
    chk(justDec == (modelFill >= 12), "R6 justDec at 12", int'(justDec), 1);
    chk(justInc == 1'b0, "R6 justInc", int'(justInc), 0);

    // boundary with fill still at 12: handover and relatch in one cycle
    fsPulse(); rdIdle(2);
    chk(justDec == 1'b1, "R7 relatch at boundary", int'(justDec), 1);
    rdSlot(1'b1, v, d); modelFill--;
    chk(v == 1'b1, "R9 spare byte", int'(v), 1);

    fsPulse(); rdIdle(2);
    chk(justDec == 1'b0, "R7 no relatch at 11", int'(justDec), 0);
    rdSlot(1'b1, v, d); modelFill--;
    chk(v == 1'b1, "R9 spare byte from relatched request", int'(v), 1);

    fsPulse();
    rdSlot(1'b1, v, d);
    chk(v == 1'b0, "R9 spare idle without request", int'(v), 0);

    // drain the six remaining preset bytes down to fill 4
    for (int i = 0; i < 6; i++) begin
      rdSlot(1'b0, v, d); modelFill--;
      chk(v == 1'b1, "R10 normal slot byte", int'(v), 1);
    end
    rdIdle(3);
    chk(justInc == (modelFill <= 4), "R5 justInc at 4", int'(justInc), 1);

    fsPulse(); rdIdle(2);
    chk(justInc == 1'b1, "R7 relatch at 4", int'(justInc), 1);
    rdSlot(1'b0, v, d);
    chk(v == 1'b0, "R8 skipped slot", int'(v), 0);
    rdSlot(1'b0, v, d);
    chk(v == 1'b1 && d == 8'hA0, "R2 R8 first payload after skip", int'(d), 'hA0);

    fsPulse();
    rdSlot(1'b0, v, d);
    chk(v == 1'b0, "R8 skipped slot again", int'(v), 0);
    for (int i = 1; i < 4; i++) begin
      rdSlot(1'b0, v, d);
      chk(v == 1'b1 && d == 8'hA0 + 8'(i), "R2 order", int'(d), 'hA0 + i);
    end
    rdSlot(1'b0, v, d);
    chk(v == 1'b0, "R4 empty read", int'(v), 0);
    rdIdle(3);

    // overflow: 20 writes into an empty store
    for (int i = 0; i < 20; i++) wrByte(8'hC0 + 8'(i));
    rdIdle(8);
    chk(justInc == 1'b1, "R5 held within frame", int'(justInc), 1);
    chk(justDec == 1'b0, "R7 single request at fill 16", int'(justDec), 0);
    for (int i = 0; i < 16; i++) begin
      rdSlot(1'b0, v, d);
      chk(v == 1'b1 && d == 8'hC0 + 8'(i), "R3 accepted bytes", int'(d), 'hC0 + i);
    end
    rdSlot(1'b0, v, d);
    chk(v == 1'b0, "R3 R4 excess writes dropped", int'(v), 0);

    // streaming with drift and framed justification
    begin
      int expByte = 0;
      fork
        begin
          for (int i = 0; i < 300; i++) begin
            @(negedge wrClk); wrStb = 1'b1; wrData = 8'(i);
          end
          @(negedge wrClk); wrStb = 1'b0;
        end
        begin
          for (int cyc = 0; cyc < 4000 && expByte < 300; cyc++) begin
            @(negedge rdClk);
            if (rdValid) begin
              chk(rdData == 8'(expByte), "R2 stream order", int'(rdData), expByte % 256);
              expByte++;
            end
            frameStart = (cyc % 32) == 0;
            rdSpare    = (cyc % 32) == 1;
            rdReq      = (cyc % 32) > 1;
          end
          frameStart = 1'b0; rdSpare = 1'b0; rdReq = 1'b0;
        end
      join
      chk(expByte == 300, "R2 stream complete", expByte, 300);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule